// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Front End

This block is the digital side of a two-channel 14-bit voltage converter. A host shifts command words in over a three-wire serial port: a serial clock, a data line and an active-low select that also acts as the load strobe. The serial pins are brought into the system clock domain through synchronizer stages. Each rising serial clock edge seen while the select is low pushes one bit into a 32-bit shift register. The oldest bit of that register leaves on a serial data output, so several parts can be chained on one data line.

When the select returns high, the block decodes the most recent 24 bits as one command. That word holds a 4-bit command, a 4-bit address and a 14-bit code, followed by two padding bits. Each channel keeps a pending latch and a separate output register. The output register drives that channel's converter code. Commands can write the latch, move the latch to the output, or do both at once. Other commands enter power-down or pick the fast or slow settling mode.

An asynchronous clear input forces both output codes to zero at once. A power-on reset puts every register into a known state.

Top module: `dual_dac_serial_if`

## Requirements
- R1: After reset, code_a and code_b are 0, fast_mode is 0 (slow is the default) and shutdown is 0.
- R2: A bit on sdi enters the shift register on each rising sck edge while cs_ld is low. sck edges while cs_ld is high shift nothing, and neither the register nor sdo changes.
- R3: On each rising edge of cs_ld the last 24 bits shifted in are decoded, first bit received first: command [23:20], address [19:16], code [15:2]. The two final bits are ignored.
- R4: A 32-bit frame decodes exactly like its last 24 bits. The first 8 bits have no effect on the command.
- R5: sdo always shows the bit shifted in 32 rising sck edges earlier (the last register stage). It is 0 after reset.
- R6: Command 0 writes the code into the addressed channel's latch and leaves that channel's output code unchanged.
- R7: Command 1 copies the addressed channel's latch into its output code.
- R8: Command 2 writes the code into both the latch and the output code of the addressed channel.
- R9: Address 0 selects channel A, address 1 selects channel B and address 0xF selects both channels.
- R10: Command 3 sets shutdown. Command 4 sets fast_mode to 1. Command 5 sets fast_mode to 0.
- R11: Commands 0, 1 and 2 with a valid address clear shutdown.
- R12: Commands 6 to 15, and addresses 2 to 14, leave all outputs and latches unchanged.
- R13: While clr_n is low, code_a and code_b are 0, whatever the clock is doing. The latches keep their contents, so a later command 1 restores the outputs.
- R14: Outputs change only at a decoded load or at a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of both output codes |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data in |
| cs_ld | input | 1 | Active-low select; its rising edge loads the command |
| sdo | output | 1 | Serial data out, the last shift stage |
| code_a | output | 14 | Channel A converter code |
| code_b | output | 14 | Channel B converter code |
| fast_mode | output | 1 | 1 = fast settling, 0 = slow settling |
| shutdown | output | 1 | 1 = converter powered down |

## Verification
The hardest state to reach from the pins is a channel whose pending latch differs from its output code while a clear or a shutdown is active. This is the only state in which a later command 1 shows whether the latch survived. The bench builds it on purpose: it writes the latch only, applies the clear across clock edges, and then issues a transfer. Full shift register contents are hard to see from the ports, so the bench compares sdo before every serial clock edge of every frame with its own 32-bit model. A bit lost or shifted while the select was high therefore shows up later in the stream.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;
    parameter int CODE_W  = 14;
    parameter int FRAME_W = 32;
    parameter int WORD_W  = 24;
    parameter int FIELD_W = 4;
    parameter int NUM_CH  = 2;

    // Command and address fields plus the channel code
    localparam int DEC_W = 2 * FIELD_W + CODE_W;

    typedef enum logic [FIELD_W-1:0] {
        CMD_WRITE  = 4'd0,
        CMD_UPDATE = 4'd1,
        CMD_WRUPD  = 4'd2,
        CMD_SLEEP  = 4'd3,
        CMD_FAST   = 4'd4,
        CMD_SLOW   = 4'd5
    } cmd_e;

    localparam logic [FIELD_W-1:0] ADDR_ALL = 4'hF;

    typedef struct packed {
        logic [NUM_CH-1:0] wr;
        logic [NUM_CH-1:0] upd;
        logic              sleep;
        logic              fast;
        logic              slow;
    } dec_t;
endpackage

// File: rtl/dac_shift.sv
module dac_shift #(
    parameter int FRAME_W = 32,
    parameter int SYNC_N  = 2,
    parameter int OUT_W   = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             sdi,
    input  logic             cs_ld,
    output logic [OUT_W-1:0] word,
    output logic             load,
    output logic             cs_high,
    output logic             sdo
);
    localparam int WORD_TOP = 24;

    typedef struct packed {
        logic [SYNC_N-1:0]  sck_s;
        logic [SYNC_N-1:0]  sdi_s;
        logic [SYNC_N-1:0]  cs_s;
        logic               sck_p;
        logic               cs_p;
        logic [FRAME_W-1:0] sr;
    } st_t;

    st_t st_d, st_q;
    logic sck_now, sdi_now, cs_now;

    assign sck_now = st_q.sck_s[SYNC_N-1];
    assign sdi_now = st_q.sdi_s[SYNC_N-1];
    assign cs_now  = st_q.cs_s[SYNC_N-1];

    always_comb begin
        st_d       = st_q;
        st_d.sck_s = {st_q.sck_s[SYNC_N-2:0], sck};
        st_d.sdi_s = {st_q.sdi_s[SYNC_N-2:0], sdi};
        st_d.cs_s  = {st_q.cs_s[SYNC_N-2:0], cs_ld};
        st_d.sck_p = sck_now;
        st_d.cs_p  = cs_now;
        if (sck_now && !st_q.sck_p && !cs_now) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], sdi_now};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck_s <= '0;
            st_q.sdi_s <= '0;
            st_q.cs_s  <= '1;
            st_q.sck_p <= 1'b0;
            st_q.cs_p  <= 1'b1;
            st_q.sr    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load    = cs_now & ~st_q.cs_p;
    assign cs_high = cs_now;
    assign sdo     = st_q.sr[FRAME_W-1];
    assign word    = st_q.sr[WORD_TOP-1 -: OUT_W];
endmodule

// File: rtl/dac_decode.sv
module dac_decode
    import dac_if_pkg::*;
(
    input  logic             load,
    input  logic [DEC_W-1:0] word,
    output dec_t             dec,
    output logic [CODE_W-1:0] data
);
    logic [FIELD_W-1:0] cmd, addr;
    logic [NUM_CH-1:0]  sel;

    assign cmd  = word[DEC_W-1 -: FIELD_W];
    assign addr = word[DEC_W-FIELD_W-1 -: FIELD_W];
    assign data = word[CODE_W-1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign sel[i] = (addr == FIELD_W'(i)) || (addr == ADDR_ALL);
    end

    always_comb begin
        dec = '0;
        if (load && (|sel)) begin
            case (cmd_e'(cmd))
                CMD_WRITE:  dec.wr  = sel;
                CMD_UPDATE: dec.upd = sel;
                CMD_WRUPD: begin
                    dec.wr  = sel;
                    dec.upd = sel;
                end
                CMD_SLEEP:  dec.sleep = 1'b1;
                CMD_FAST:   dec.fast  = 1'b1;
                CMD_SLOW:   dec.slow  = 1'b1;
                default:    dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              wr,
    input  logic              upd,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] latch_d, latch_q;
    logic [CODE_W-1:0] out_d, out_q;
    logic              out_rst_n;

    assign out_rst_n = rst_n & clr_n;

    always_comb begin
        latch_d = latch_q;
        out_d   = out_q;
        if (wr) begin
            latch_d = data;
        end
        if (upd) begin
            out_d = wr ? data : latch_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    always_ff @(posedge clk or negedge out_rst_n) begin
        if (!out_rst_n) out_q <= '0;
        else            out_q <= out_d;
    end

    assign code = out_q;
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
    import dac_if_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              cs_ld,
    output logic              sdo,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b,
    output logic              fast_mode,
    output logic              shutdown
);
    typedef struct packed {
        logic fast;
        logic sleep;
    } ctl_t;

    logic [DEC_W-1:0]  word;
    logic              load;
    logic              cs_high;
    dec_t              dec;
    logic [CODE_W-1:0] data;
    logic [CODE_W-1:0] codes [NUM_CH];
    ctl_t              ctl_d, ctl_q;

    dac_shift #(
        .FRAME_W(FRAME_W),
        .SYNC_N (SYNC_N),
        .OUT_W  (DEC_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck    (sck),
        .sdi    (sdi),
        .cs_ld  (cs_ld),
        .word   (word),
        .load   (load),
        .cs_high(cs_high),
        .sdo    (sdo)
    );

    dac_decode u_dec (
        .load(load),
        .word(word),
        .dec (dec),
        .data(data)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dac_channel #(.CODE_W(CODE_W)) u_ch (
            .clk  (clk),
            .rst_n(rst_n),
            .clr_n(clr_n),
            .wr   (dec.wr[i]),
            .upd  (dec.upd[i]),
            .data (data),
            .code (codes[i])
        );
    end

    always_comb begin
        ctl_d = ctl_q;
        if (dec.sleep)            ctl_d.sleep = 1'b1;
        if (|(dec.wr | dec.upd))  ctl_d.sleep = 1'b0;
        if (dec.fast)             ctl_d.fast  = 1'b1;
        if (dec.slow)             ctl_d.fast  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign code_a    = codes[0];
    assign code_b    = codes[1];
    assign fast_mode = ctl_q.fast;
    assign shutdown  = ctl_q.sleep;
endmodule

// File: rtl/dac_if_checker.sv
module dac_if_checker #(
    parameter int CODE_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              load,
    input logic              cs_high,
    input logic              sdo,
    input logic [CODE_W-1:0] code_a,
    input logic [CODE_W-1:0] code_b,
    input logic              fast_mode,
    input logic              shutdown
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_reset_state_r1: assert (code_a == '0 && code_b == '0 && !fast_mode && !shutdown)
                else $error("reset state violated");
        end
    end

    p_clear_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (code_a == '0 && code_b == '0));

    p_no_change_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && clr_n) |=> (!clr_n || ($stable(code_a) && $stable(code_b))));

    p_shift_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |=> $stable(sdo));

    p_mode_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fast_mode) || $fell(fast_mode) || $rose(shutdown)) |-> $past(load));

    p_wake_on_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shutdown) |-> $past(load));
endmodule

bind dual_dac_serial_if dac_if_checker #(.CODE_W(dac_if_pkg::CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .load     (load),
    .cs_high  (cs_high),
    .sdo      (sdo),
    .code_a   (code_a),
    .code_b   (code_b),
    .fast_mode(fast_mode),
    .shutdown (shutdown)
);

// File: tb/test_dual_dac_serial_if.sv
module test_dual_dac_serial_if;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic cs_ld = 1'b1;
    logic sdo, fast_mode, shutdown;
    logic [13:0] code_a, code_b;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model
    logic [31:0] m_sr = '0;
    logic [13:0] m_lat [2];
    logic [13:0] m_out [2];
    logic m_fast = 0, m_sd = 0;

    always #10 clk = ~clk;

    dual_dac_serial_if i_dual_dac_serial_if (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sck(sck), .sdi(sdi),
        .cs_ld(cs_ld), .sdo(sdo), .code_a(code_a), .code_b(code_b),
        .fast_mode(fast_mode), .shutdown(shutdown)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model_apply(input logic [23:0] w);
        logic [3:0] c, a;
        logic [13:0] d;
        bit sa, sb;
        c = w[23:20];
        a = w[19:16];
        d = w[15:2];
        sa = (a == 4'h0) || (a == 4'hF);
        sb = (a == 4'h1) || (a == 4'hF);
        if (!(sa || sb)) return;
        case (c)
            4'd0: begin if (sa) m_lat[0] = d; if (sb) m_lat[1] = d; end
            4'd1: begin if (sa) m_out[0] = m_lat[0]; if (sb) m_out[1] = m_lat[1]; end
            4'd2: begin
                if (sa) begin m_lat[0] = d; m_out[0] = d; end
                if (sb) begin m_lat[1] = d; m_out[1] = d; end
            end
            4'd3: m_sd = 1;
            4'd4: m_fast = 1;
            4'd5: m_fast = 0;
            default: ;
        endcase
        if (c <= 4'd2) m_sd = 0;
    endfunction

    task automatic check_outs(input string req);
        chk(code_a == m_out[0], req, 32'(code_a), 32'(m_out[0]));
        chk(code_b == m_out[1], req, 32'(code_b), 32'(m_out[1]));
        chk({fast_mode, shutdown} == {m_fast, m_sd}, req, {30'd0, fast_mode, shutdown}, {30'd0, m_fast, m_sd});
    endtask

    // Sends the low n bits of bits, most significant first; compares sdo before each edge (R5)
    task automatic send(input logic [31:0] bits, input int n);
        bit sdo_ok = 1;
        logic [31:0] bad_act = '0, bad_exp = '0;
        cs_ld = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            repeat (4) @(negedge clk);
            if (sdo !== m_sr[31] && sdo_ok) begin
                sdo_ok = 0; bad_act = 32'(sdo); bad_exp = 32'(m_sr[31]);
            end
            sck = 1'b1;
            m_sr = {m_sr[30:0], bits[i]};
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_ld = 1'b1;
        repeat (8) @(negedge clk);
        model_apply(m_sr[23:0]);
        chk(sdo_ok, "R5 sdo stream", bad_act, bad_exp);
    endtask

    function automatic logic [23:0] mk(input logic [3:0] c, input logic [3:0] a, input logic [13:0] d, input logic [1:0] pad);
        return {c, a, d, pad};
    endfunction

    initial begin
        m_lat[0] = '0; m_lat[1] = '0; m_out[0] = '0; m_out[1] = '0;
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1654));
        repeat (3) @(negedge clk);
        check_outs("R1 reset");
        chk(sdo == 1'b0, "R1/R5 sdo after reset", 32'(sdo), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6: latch only
        send(32'(mk(4'd0, 4'd0, 14'h1234, 2'b11)), 24);
        check_outs("R6 write latch A");
        // R7: transfer
        send(32'(mk(4'd1, 4'd0, 14'h0, 2'b00)), 24);
        check_outs("R7 update A");
        chk(code_a == 14'h1234, "R7 code_a value", 32'(code_a), 32'h1234);
        // R8 and R9 on channel B
        send(32'(mk(4'd2, 4'd1, 14'h3ABC, 2'b01)), 24);
        check_outs("R8 write+update B");
        chk(code_b == 14'h3ABC && code_a == 14'h1234, "R9 only B changed", 32'(code_b), 32'h3ABC);
        // R9 both
        send(32'(mk(4'd2, 4'hF, 14'h2222, 2'b10)), 24);
        check_outs("R9 address all");
        // R10 and R11
        send(32'(mk(4'd3, 4'd0, 14'h0, 2'b00)), 24);
        chk(shutdown == 1'b1, "R10 shutdown set", 32'(shutdown), 1);
        send(32'(mk(4'd0, 4'd1, 14'h0555, 2'b00)), 24);
        chk(shutdown == 1'b0, "R11 write wakes", 32'(shutdown), 0);
        check_outs("R11 latch B only");
        send(32'(mk(4'd4, 4'd1, 14'h0, 2'b00)), 24);
        chk(fast_mode == 1'b1, "R10 fast", 32'(fast_mode), 1);
        send(32'(mk(4'd5, 4'hF, 14'h0, 2'b00)), 24);
        chk(fast_mode == 1'b0, "R10 slow", 32'(fast_mode), 0);
        // R12: unknown command / unused address
        send(32'(mk(4'd7, 4'd0, 14'h3FFF, 2'b00)), 24);
        check_outs("R12 unknown command");
        send(32'(mk(4'd2, 4'd5, 14'h3FFF, 2'b00)), 24);
        check_outs("R12 unused address");
        // R4: daisy frame whose leading byte looks like a command
        send({8'h2F, mk(4'd2, 4'd0, 14'h0ACE, 2'b11)}, 32);
        check_outs("R4 daisy frame");
        chk(code_a == 14'h0ACE, "R3/R4 code field", 32'(code_a), 32'h0ACE);
        // R2: sck while deselected shifts nothing
        for (int k = 0; k < 6; k++) begin
            sdi = ~m_sr[31];
            repeat (4) @(negedge clk); sck = 1'b1;
            repeat (4) @(negedge clk); sck = 1'b0;
        end
        repeat (6) @(negedge clk);
        chk(sdo == m_sr[31], "R2 sdo unchanged while deselected", 32'(sdo), 32'(m_sr[31]));
        check_outs("R2 no load while deselected");
        send(32'(mk(4'hF, 4'hF, 14'h0, 2'b00)), 32);
        // R13: clear keeps latches
        send(32'(mk(4'd0, 4'hF, 14'h1111, 2'b00)), 24);
        #5 clr_n = 1'b0;
        #1;
        chk(code_a == 0 && code_b == 0, "R13 async clear", {code_a, code_b}, 0);
        m_out[0] = '0; m_out[1] = '0;
        repeat (3) @(negedge clk);
        check_outs("R13 clear held");
        clr_n = 1'b1;
        repeat (3) @(negedge clk);
        check_outs("R14 no change after clear release");
        send(32'(mk(4'd1, 4'hF, 14'h0, 2'b00)), 24);
        chk(code_a == 14'h1111 && code_b == 14'h1111, "R13 latch kept", {code_a, code_b}, {14'h1111, 14'h1111});

        // constrained random
        for (int r = 0; r < 250; r++) begin
            logic [3:0] c, a;
            logic [15:0] d;
            int pc = $urandom_range(0, 9);
            int pa = $urandom_range(0, 7);
            c = (pc < 8) ? 4'($urandom_range(0, 5)) : 4'($urandom_range(6, 15));
            a = (pa < 2) ? 4'd0 : (pa < 4) ? 4'd1 : (pa < 6) ? 4'hF : 4'($urandom_range(2, 14));
            d = 16'($urandom);
            if ($urandom_range(0, 1) == 0)
                send(32'({c, a, d}), 24);
            else
                send({8'($urandom), c, a, d}, 32);
            check_outs("R3/R6/R7/R8/R9/R12/R14 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule